// File: doc/BRIEF.md
# Serial programming command receiver

This block is the target-side front end of a two-wire in-circuit programming port. An external host toggles a programming clock pin and drives, or samples, a shared data pin. The block brings both pins into the fast system clock domain through a synchroniser and detects the clock edges there. It then shifts in 6-bit commands and turns each recognised command into a one-cycle strobe for the memory controller behind it.

Two commands carry a data word: load and read. Each is followed by a 16-clock frame. The first and last clocks of the frame are dummy start and stop bits, and the 14 clocks between them carry the word, least significant bit first. A loaded word is presented on a word output together with a valid pulse. A read word is taken from a word input and shifted out on the data pin, with an output enable controlling the pad's tri-state buffer.

A digital mode-enable input stands in for detection of the high-voltage entry sequence. While mode-enable is low, every register is held in reset, so the receiver always starts from a clean command boundary when the mode is entered. The system clock must run at least 8 times faster than the programming clock.

Top module: `prog_cmd_rx`

## Requirements
- R1: A command is 6 programming-clock periods long. Each bit is taken from the data pin at a falling edge of the programming clock, and the first bit is the command's bit 0.
- R2: Bits 5:4 of a command are ignored. Low nibble 0010 pulses `strb_load`, 0100 pulses `strb_read`, 0110 pulses `strb_inc`, 1000 pulses `strb_begin`, 1110 pulses `strb_end` and 1001 pulses `strb_erase`. Each strobe is high for exactly one system cycle, and no two strobes or `wr_valid` are ever high in the same cycle.
- R3: Any other command value raises no strobe and starts no data frame: the next 6 programming clocks form a new command.
- R4: A load or a read command is followed by a frame of exactly 16 programming clocks. After the 16th falling edge of the frame, the receiver waits for a new command.
- R5: For a load, the data-pin values at the falling edges of frame clocks 2 to 15 form a 14-bit word, bit 0 first. The value at frame clocks 1 and 16 is not used. `wr_word` carries bits 11:0 of that word, and bits 13:12 are dropped. `wr_valid` pulses once, after the 16th falling edge of the frame.
- R6: For a read, `pdat_oe` is low through the first clock of the frame. It goes high after the 2nd rising edge of the frame and returns low after the 16th rising edge.
- R7: For a read, `rd_word` is sampled at the 1st rising edge of the frame. The 14-bit value {2'b11, rd_word} is then shifted out on `pdat_out`, bit 0 first. The data bit changes after each rising edge from the 2nd to the 15th, so the host can sample it at the following falling edge.
- R8: While `mode_en` is low, the whole receiver is held in reset. A partly received command is discarded, a data frame in progress is abandoned and `pdat_oe` is forced low. When `mode_en` returns high, the receiver starts from a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Programming mode active; low holds the block in reset |
| pclk_pin | input | 1 | Programming clock pin, asynchronous |
| pdat_pin | input | 1 | Data pin input path, asynchronous |
| pdat_out | output | 1 | Data pin output value during a read |
| pdat_oe | output | 1 | Data pin output enable |
| strb_load | output | 1 | Load command decoded |
| strb_read | output | 1 | Read command decoded |
| strb_inc | output | 1 | Increment-address command decoded |
| strb_begin | output | 1 | Begin-programming command decoded |
| strb_end | output | 1 | End-programming command decoded |
| strb_erase | output | 1 | Bulk-erase command decoded |
| wr_word | output | 12 | Word received by a load frame |
| wr_valid | output | 1 | One-cycle pulse: `wr_word` is new |
| rd_word | input | 12 | Word to be sent by a read frame |

## Verification
A bit counter that slips by one changes every later command at the ports. A command is then decoded wrongly or comes out as an unknown value, or a load word shows up shifted by one bit on `wr_word`, within the same 6 or 16 programming clocks. A frame state that is not left at the right clock eats the next command's bits, so the strobe the host expects never appears. A wrong read counter shows at once as `pdat_oe` opening one clock early or late, or as a data bit off by one position at a host falling edge. Dropping `mode_en` in the middle of a command or a read frame, and then issuing a fresh command, shows whether the counters really restart.

// File: rtl/prx_pkg.sv
package prx_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_READ, K_INC, K_BEGIN, K_END, K_ERASE
  } cmd_kind_e;

  typedef enum logic {
    ST_CMD,
    ST_FRAME
  } rx_state_e;
endpackage

// File: rtl/prx_pin_sync.sv
module prx_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_clk,
  input  logic pin_dat,
  output logic clk_rise,
  output logic clk_fall,
  output logic dat_sync
);
  logic [STAGES-1:0] c_pipe;
  logic [STAGES-1:0] d_pipe;
  logic              c_last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          c_pipe <= '0;
          d_pipe <= '0;
        end else begin
          c_pipe <= pin_clk;
          d_pipe <= pin_dat;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          c_pipe <= '0;
          d_pipe <= '0;
        end else begin
          c_pipe <= {c_pipe[STAGES-2:0], pin_clk};
          d_pipe <= {d_pipe[STAGES-2:0], pin_dat};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) c_last <= 1'b0;
    else     c_last <= c_pipe[STAGES-1];
  end

  assign clk_rise = c_pipe[STAGES-1] & ~c_last;
  assign clk_fall = ~c_pipe[STAGES-1] & c_last;
  assign dat_sync = d_pipe[STAGES-1];
endmodule

// File: rtl/prx_decode.sv
module prx_decode
  import prx_pkg::*;
(
  input  logic [3:0] op,
  output cmd_kind_e  kind
);
  always_comb begin
    unique case (op)
      4'b0010: kind = K_LOAD;
      4'b0100: kind = K_READ;
      4'b0110: kind = K_INC;
      4'b1000: kind = K_BEGIN;
      4'b1110: kind = K_END;
      4'b1001: kind = K_ERASE;
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/prog_cmd_rx.sv
module prog_cmd_rx
  import prx_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int FRAME_W     = 14,
  parameter int CMD_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              pclk_pin,
  input  logic              pdat_pin,
  output logic              pdat_out,
  output logic              pdat_oe,
  output logic              strb_load,
  output logic              strb_read,
  output logic              strb_inc,
  output logic              strb_begin,
  output logic              strb_end,
  output logic              strb_erase,
  output logic [WORD_W-1:0] wr_word,
  output logic              wr_valid,
  input  logic [WORD_W-1:0] rd_word
);
  localparam int FRAME_CLKS = FRAME_W + 2;
  localparam int CNT_W      = $clog2(FRAME_CLKS + 1);
  localparam int CCNT_W     = $clog2(CMD_W + 1);
  localparam int PAD_W      = FRAME_W - WORD_W;
  localparam logic [CNT_W-1:0]  LAST_CLK  = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(FRAME_W);
  localparam logic [CCNT_W-1:0] LAST_CMD  = CCNT_W'(CMD_W - 1);

  logic rst_i;
  assign rst_i = rst | ~mode_en;

  logic clk_rise, clk_fall, dat_sync;

  prx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst_i),
    .pin_clk  (pclk_pin),
    .pin_dat  (pdat_pin),
    .clk_rise (clk_rise),
    .clk_fall (clk_fall),
    .dat_sync (dat_sync)
  );

  rx_state_e         state;
  logic [CMD_W-2:0]  cmd_sr;
  logic [CMD_W-1:0]  full_code;
  logic [CCNT_W-1:0] cmd_cnt;
  logic              is_read;
  logic [CNT_W-1:0]  fall_cnt;
  logic [CNT_W-1:0]  rise_cnt;
  logic [FRAME_W-1:0] rx_sr;
  logic [FRAME_W-1:0] tx_sr;
  cmd_kind_e         kind;

  assign full_code = {dat_sync, cmd_sr};

  prx_decode u_dec (
    .op   (full_code[3:0]),
    .kind (kind)
  );

  always_ff @(posedge clk) begin
    if (rst_i) begin
      state      <= ST_CMD;
      cmd_sr     <= '0;
      cmd_cnt    <= '0;
      is_read    <= 1'b0;
      fall_cnt   <= '0;
      rise_cnt   <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      pdat_out   <= 1'b0;
      pdat_oe    <= 1'b0;
      strb_load  <= 1'b0;
      strb_read  <= 1'b0;
      strb_inc   <= 1'b0;
      strb_begin <= 1'b0;
      strb_end   <= 1'b0;
      strb_erase <= 1'b0;
      wr_word    <= '0;
      wr_valid   <= 1'b0;
    end else begin
      strb_load  <= 1'b0;
      strb_read  <= 1'b0;
      strb_inc   <= 1'b0;
      strb_begin <= 1'b0;
      strb_end   <= 1'b0;
      strb_erase <= 1'b0;
      wr_valid   <= 1'b0;
      unique case (state)
        ST_CMD: begin
          if (clk_fall) begin
            cmd_sr <= full_code[CMD_W-1:1];
            if (cmd_cnt == LAST_CMD) begin
              cmd_cnt    <= '0;
              strb_load  <= (kind == K_LOAD);
              strb_read  <= (kind == K_READ);
              strb_inc   <= (kind == K_INC);
              strb_begin <= (kind == K_BEGIN);
              strb_end   <= (kind == K_END);
              strb_erase <= (kind == K_ERASE);
              if (kind == K_LOAD || kind == K_READ) begin
                state    <= ST_FRAME;
                is_read  <= (kind == K_READ);
                fall_cnt <= '0;
                rise_cnt <= '0;
              end
            end else begin
              cmd_cnt <= cmd_cnt + 1'b1;
            end
          end
        end
        ST_FRAME: begin
          if (clk_rise) begin
            rise_cnt <= rise_cnt + 1'b1;
            if (rise_cnt == '0) begin
              tx_sr <= {{PAD_W{1'b1}}, rd_word};
            end else if (is_read && rise_cnt <= LAST_BIT) begin
              pdat_out <= tx_sr[0];
              tx_sr    <= {1'b1, tx_sr[FRAME_W-1:1]};
              pdat_oe  <= 1'b1;
            end else begin
              pdat_oe <= 1'b0;
            end
          end
          if (clk_fall) begin
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt != '0 && fall_cnt <= LAST_BIT)
              rx_sr <= {dat_sync, rx_sr[FRAME_W-1:1]};
            if (fall_cnt == LAST_CLK) begin
              state   <= ST_CMD;
              pdat_oe <= 1'b0;
              if (!is_read) begin
                wr_valid <= 1'b1;
                wr_word  <= rx_sr[WORD_W-1:0];
              end
            end
          end
        end
        default: state <= ST_CMD;
      endcase
    end
  end

  // R2: strobes and the write pulse never overlap
  a_r2_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb_load, strb_read, strb_inc, strb_begin, strb_end, strb_erase, wr_valid}));

  // R6: the pad is driven only inside a read frame
  a_r6_oe_in_read: assert property (@(posedge clk) disable iff (rst)
    pdat_oe |-> (state == ST_FRAME && is_read));

  // R6: output enable opens only after a programming-clock rise
  a_r6_oe_opens_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pdat_oe) |-> $past(clk_rise));

  // R5: a loaded word appears only after a programming-clock fall
  a_r5_wr_after_fall: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(clk_fall));

  // R8: mode off silences the block on the next cycle
  a_r8_mode_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (!pdat_oe && !wr_valid &&
                  !(strb_load | strb_read | strb_inc | strb_begin | strb_end | strb_erase)));
endmodule

// File: tb/tb_prog_cmd_rx.sv
module tb_prog_cmd_rx;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic pclk_pin = 1'b0;
  logic pdat_pin = 1'b0;
  logic pdat_out, pdat_oe;
  logic strb_load, strb_read, strb_inc, strb_begin, strb_end, strb_erase;
  logic [11:0] wr_word;
  logic wr_valid;
  logic [11:0] rd_word = 12'h000;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int expq[$];

  always #2 clk = ~clk;

  prog_cmd_rx dut (
    .clk(clk), .rst(rst), .mode_en(mode_en), .pclk_pin(pclk_pin), .pdat_pin(pdat_pin),
    .pdat_out(pdat_out), .pdat_oe(pdat_oe), .strb_load(strb_load), .strb_read(strb_read),
    .strb_inc(strb_inc), .strb_begin(strb_begin), .strb_end(strb_end), .strb_erase(strb_erase),
    .wr_word(wr_word), .wr_valid(wr_valid), .rd_word(rd_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected events as the design raises them
  task automatic got_ev(input int kind, input logic [11:0] d);
    int e;
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL R3 actual=%0h expected=none", kind * 4096 + int'(d));
    end else begin
      e = expq.pop_front();
      if (e != kind * 4096 + int'(d)) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", (kind == 7) ? "R5" : "R2",
                 kind * 4096 + int'(d), e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (strb_load)  got_ev(1, 12'h0);
      if (strb_read)  got_ev(2, 12'h0);
      if (strb_inc)   got_ev(3, 12'h0);
      if (strb_begin) got_ev(4, 12'h0);
      if (strb_end)   got_ev(5, 12'h0);
      if (strb_erase) got_ev(6, 12'h0);
      if (wr_valid)   got_ev(7, wr_word);
    end
  end

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pbit(input logic b);
    pclk_pin = 1'b1;
    pdat_pin = b;
    wait_sys(H);
    pclk_pin = 1'b0;
    wait_sys(H);
  endtask

  task automatic send_cmd(input logic [5:0] c, input int kind);
    if (kind != 0) expq.push_back(kind * 4096);
    for (int i = 0; i < 6; i++) pbit(c[i]);
  endtask

  task automatic do_load(input logic [5:0] c, input logic [13:0] w);
    send_cmd(c, 1);
    expq.push_back(7 * 4096 + int'(w[11:0]));
    pbit(~w[0]);
    for (int i = 0; i < 14; i++) pbit(w[i]);
    pbit(~w[13]);
  endtask

  task automatic do_read(input logic [11:0] w);
    logic [13:0] exp14;
    exp14 = {2'b11, w};
    rd_word = w;
    send_cmd(6'b000100, 2);
    for (int k = 1; k <= 16; k++) begin
      pclk_pin = 1'b1;
      pdat_pin = 1'b0;
      wait_sys(H - 1);
      if (k == 1 || k == 16) chk("R6", int'(pdat_oe), 0);
      else begin
        chk("R6", int'(pdat_oe), 1);
        chk("R7", int'(pdat_out), int'(exp14[k-2]));
      end
      wait_sys(1);
      pclk_pin = 1'b0;
      wait_sys(H);
    end
    rd_word = 12'h000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_sys(5);
    rst = 1'b0;
    wait_sys(3);
    chk("R8", int'({pdat_oe, strb_load, strb_read, strb_inc, wr_valid}), 0);
    mode_en = 1'b1;
    wait_sys(5);

    // R1 R2: every command, upper two bits set in some
    send_cmd(6'b000110, 3);
    send_cmd(6'b111000, 4);
    send_cmd(6'b011110, 5);
    send_cmd(6'b101001, 6);
    // R3: unknown codes ignored, next command still framed
    send_cmd(6'b000000, 0);
    send_cmd(6'b111111, 0);
    send_cmd(6'b000011, 0);
    send_cmd(6'b000110, 3);
    // R4 R5: loads, upper bits dropped
    do_load(6'b000010, 14'h3ABC);
    do_load(6'b110010, 14'h0001);
    do_load(6'b000010, 14'h2800);
    send_cmd(6'b001000, 4);
    // R6 R7: reads
    do_read(12'h5A3);
    do_read(12'h000);
    do_read(12'hFFF);
    send_cmd(6'b000110, 3);
    // R8: abort partial command
    pbit(1'b0); pbit(1'b1); pbit(1'b1);
    mode_en = 1'b0;
    wait_sys(4);
    chk("R8", int'(pdat_oe), 0);
    mode_en = 1'b1;
    wait_sys(4);
    send_cmd(6'b000110, 3);
    // R8: abort read frame while the pad is driven
    rd_word = 12'h0F0;
    send_cmd(6'b000100, 2);
    for (int k = 1; k <= 4; k++) pbit(1'b0);
    chk("R8", int'(pdat_oe), 1);
    mode_en = 1'b0;
    wait_sys(2);
    chk("R8", int'(pdat_oe), 0);
    mode_en = 1'b1;
    wait_sys(4);
    send_cmd(6'b001110, 5);
    do_load(6'b000010, 14'h1234);
    wait_sys(20);
    chk("R4", expq.size(), 0);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule